// File: doc/BRIEF.md
# Receive Sample Input Crossbar

This block sits in front of four receive downconversion channels. Each channel has an in-phase (I) input and a quadrature (Q) input. Every cycle the block takes four signed converter samples. A 32-bit routing word decides which converter sample feeds each channel input. A Q input can also be tied to constant zero, which suits real-only sampling. The four routed I/Q pairs leave through a register, together with a valid strobe.

The routing word arrives through a simple write port. Each write is checked before it is accepted. A word that breaks the coding rules is dropped, the routing in force is kept, and a sticky error flag is raised. An accepted word first waits in a pending slot. It becomes active only after a sample has been consumed, so every output pair is built from one routing setting only.

Top module: `rx_input_xbar`

## Requirements
- R1: For channel c, bits [8c+3:8c] of the routing word hold the I selector. I selector value k (0 to 3) routes converter sample k (bits [16k+15:16k] of `adc_data`) to `out_i` bits [16c+15:16c].
- R2: For channel c, bits [8c+7:8c+4] of the routing word hold the Q selector. Q selector value k (0 to 3) routes converter sample k to `out_q` bits [16c+15:16c].
- R3: Q selector value 0xF drives that channel's `out_q` slice to zero.
- R4: A written word is illegal when any of these holds: an I selector is above 3; a Q selector is neither 0 to 3 nor 0xF; or some Q selectors, but not all, are 0xF. An illegal write sets `cfg_err` at the clock edge that ends the write cycle. `cfg_err` then stays set until reset.
- R5: An illegal write changes neither the active routing nor any routing word still pending.
- R6: A legal write held in cycle t goes into a pending slot. The first valid sample in a cycle after t still uses the old routing. Samples after that one use the new routing.
- R7: `out_valid` equals `adc_valid` delayed by one clock. The output slices update at the edge that ends a valid input cycle and hold their values while no sample is valid.
- R8: After reset, `out_valid`, `out_i`, `out_q` and `cfg_err` are zero. The active routing is then 0xF3F2F1F0: channel c takes I from sample c, and every Q input is zero.
- R9: When several legal writes come before the next valid sample, the last one written is the one that takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Routing word write strobe |
| cfg_wdata | input | 32 | Routing word being written |
| adc_valid | input | 1 | The converter samples are valid this cycle |
| adc_data | input | 64 | Four signed 16-bit converter samples, sample k in bits [16k+15:16k] |
| out_valid | output | 1 | Routed pair valid, one clock after `adc_valid` |
| out_i | output | 64 | Routed I samples, channel c in bits [16c+15:16c] |
| out_q | output | 64 | Routed Q samples, channel c in bits [16c+15:16c] |
| cfg_err | output | 1 | Sticky flag for an illegal routing write |

## Verification
If the active routing register held a wrong value, the error would appear on the very next valid output pair. The affected channel slices would carry another converter's sample, or zero where a sample was expected. Each converter sample carries a distinct value, so any misrouted slice is visible in that pair. A pending slot that commits too early or too late shows up as exactly one pair routed with the wrong setting, namely the pair right after a write. A wrong error state shows on `cfg_err` one clock after the offending write.

// File: rtl/rx_xbar_pkg.sv
package rx_xbar_pkg;
    localparam int FIELD_W = 4;
    localparam logic [FIELD_W-1:0] ZERO_CODE = 4'hF;
endpackage

// File: rtl/rx_xbar_cfg_check.sv
module rx_xbar_cfg_check
    import rx_xbar_pkg::*;
#(
    parameter int NUM_CHAN = 4,
    parameter int NUM_ADC  = 4,
    localparam int MUX_W   = NUM_CHAN * 2 * FIELD_W
) (
    input  logic [MUX_W-1:0] word,
    output logic             legal
);
    logic [NUM_CHAN-1:0] i_ok;
    logic [NUM_CHAN-1:0] q_num;
    logic [NUM_CHAN-1:0] q_zero;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_field
        logic [FIELD_W-1:0] i_f;
        logic [FIELD_W-1:0] q_f;
        assign i_f       = word[c*2*FIELD_W +: FIELD_W];
        assign q_f       = word[c*2*FIELD_W + FIELD_W +: FIELD_W];
        assign i_ok[c]   = i_f < FIELD_W'(NUM_ADC);
        assign q_num[c]  = q_f < FIELD_W'(NUM_ADC);
        assign q_zero[c] = q_f == ZERO_CODE;
    end

    assign legal = (&i_ok) && ((&q_zero) || (&q_num));
endmodule

// File: rtl/rx_xbar_cfg_reg.sv
module rx_xbar_cfg_reg
    import rx_xbar_pkg::*;
#(
    parameter int NUM_CHAN = 4,
    localparam int MUX_W   = NUM_CHAN * 2 * FIELD_W,
    parameter logic [MUX_W-1:0] RESET_MUX = 32'hF3F2F1F0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [MUX_W-1:0] cfg_wdata,
    input  logic             wr_legal,
    input  logic             sample_take,
    output logic [MUX_W-1:0] active_mux,
    output logic             cfg_err
);
    typedef struct packed {
        logic [MUX_W-1:0] active;
        logic [MUX_W-1:0] pend;
        logic             pend_vld;
        logic             err;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_take && st_q.pend_vld) begin
            st_d.active   = st_q.pend;
            st_d.pend_vld = 1'b0;
        end
        if (cfg_wr) begin
            if (wr_legal) begin
                st_d.pend     = cfg_wdata;
                st_d.pend_vld = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active   <= RESET_MUX;
            st_q.pend     <= RESET_MUX;
            st_q.pend_vld <= 1'b0;
            st_q.err      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_mux = st_q.active;
    assign cfg_err    = st_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R4
    AST_ILLEGAL_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !wr_legal) |=> $stable(st_q.pend)); // R5
    AST_IDLE_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_take |=> $stable(active_mux)); // R6
endmodule

// File: rtl/rx_xbar_lane.sv
module rx_xbar_lane
    import rx_xbar_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int NUM_ADC  = 4,
    localparam int DATA_W  = NUM_ADC * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [DATA_W-1:0]   adc_data,
    input  logic [FIELD_W-1:0]  i_sel,
    input  logic [FIELD_W-1:0]  q_sel,
    output logic [SAMPLE_W-1:0] lane_i,
    output logic [SAMPLE_W-1:0] lane_q
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] i;
        logic [SAMPLE_W-1:0] q;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic [SAMPLE_W-1:0] i_pick;
    logic [SAMPLE_W-1:0] q_pick;

    always_comb begin
        st_d   = st_q;
        i_pick = '0;
        q_pick = '0;
        for (int k = 0; k < NUM_ADC; k++) begin
            if (i_sel == FIELD_W'(k)) i_pick = adc_data[k*SAMPLE_W +: SAMPLE_W];
            if (q_sel == FIELD_W'(k)) q_pick = adc_data[k*SAMPLE_W +: SAMPLE_W];
        end
        if (take) begin
            st_d.i = i_pick;
            st_d.q = q_pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lane_i = st_q.i;
    assign lane_q = st_q.q;

    AST_QZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && q_sel == ZERO_CODE) |=> (lane_q == '0)); // R3
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(lane_i) && $stable(lane_q))); // R7
endmodule

// File: rtl/rx_input_xbar.sv
module rx_input_xbar
    import rx_xbar_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int NUM_ADC  = 4,
    parameter int NUM_CHAN = 4,
    localparam int MUX_W   = NUM_CHAN * 2 * FIELD_W,
    localparam int DATA_W  = NUM_ADC * SAMPLE_W,
    localparam int OUT_W   = NUM_CHAN * SAMPLE_W,
    parameter logic [MUX_W-1:0] RESET_MUX = 32'hF3F2F1F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [MUX_W-1:0]  cfg_wdata,
    input  logic              adc_valid,
    input  logic [DATA_W-1:0] adc_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_i,
    output logic [OUT_W-1:0]  out_q,
    output logic              cfg_err
);
    logic             wr_legal;
    logic [MUX_W-1:0] active_mux;
    logic             valid_d, valid_q;

    rx_xbar_cfg_check #(.NUM_CHAN(NUM_CHAN), .NUM_ADC(NUM_ADC)) chk_i (
        .word  (cfg_wdata),
        .legal (wr_legal)
    );

    rx_xbar_cfg_reg #(.NUM_CHAN(NUM_CHAN), .RESET_MUX(RESET_MUX)) cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .wr_legal    (wr_legal),
        .sample_take (adc_valid),
        .active_mux  (active_mux),
        .cfg_err     (cfg_err)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_lane
        rx_xbar_lane #(.SAMPLE_W(SAMPLE_W), .NUM_ADC(NUM_ADC)) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (adc_valid),
            .adc_data (adc_data),
            .i_sel    (active_mux[c*2*FIELD_W +: FIELD_W]),
            .q_sel    (active_mux[c*2*FIELD_W + FIELD_W +: FIELD_W]),
            .lane_i   (out_i[c*SAMPLE_W +: SAMPLE_W]),
            .lane_q   (out_q[c*SAMPLE_W +: SAMPLE_W])
        );
    end

    always_comb valid_d = adc_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_d;
    end

    assign out_valid = valid_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        adc_valid |=> out_valid); // R7
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_valid |=> !out_valid); // R7
endmodule

// File: tb/rx_input_xbar_tb.sv
module rx_input_xbar_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        adc_valid = 1'b0;
    logic [63:0] adc_data = '0;
    logic        out_valid;
    logic [63:0] out_i, out_q;
    logic        cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rx_input_xbar dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .adc_valid(adc_valid), .adc_data(adc_data), .out_valid(out_valid),
        .out_i(out_i), .out_q(out_q), .cfg_err(cfg_err)
    );

    // {routing word, expected legal}
    localparam logic [32:0] VECS [9] = '{
        {32'h03020100, 1'b1},
        {32'h01233210, 1'b1},
        {32'hF0F1F2F3, 1'b1},
        {32'hF3F2F1F4, 1'b0},
        {32'h0F000000, 1'b0},
        {32'hF3F2F100, 1'b0},
        {32'h50000000, 1'b0},
        {32'h33333333, 1'b1},
        {32'h12301230, 1'b1}
    };

    function automatic logic [127:0] route(input logic [31:0] m, input logic [63:0] d);
        logic [63:0] ri, rq;
        ri = '0; rq = '0;
        for (int c = 0; c < 4; c++) begin
            logic [3:0] is, qs;
            is = m[c*8 +: 4];
            qs = m[c*8+4 +: 4];
            ri[c*16 +: 16] = d[is[1:0]*16 +: 16];
            rq[c*16 +: 16] = (qs == 4'hF) ? 16'h0 : d[qs[1:0]*16 +: 16];
        end
        return {rq, ri};
    endfunction

    function automatic logic [63:0] mk(input int n);
        logic [63:0] r;
        for (int k = 0; k < 4; k++) r[k*16 +: 16] = 16'(16'h1000 * (k + 1) + n * 16 + k);
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic sample(input string req, input logic [63:0] d, input logic [31:0] m);
        @(negedge clk); adc_valid = 1'b1; adc_data = d;
        @(negedge clk); adc_valid = 1'b0;
        check(req, {out_q, out_i}, route(m, d));
        check({req, " valid"}, 128'(out_valid), 128'(1));
    endtask

    initial begin
        logic [31:0] cur;
        logic        err_m;
        logic [127:0] held;
        repeat (3) @(negedge clk);
        check("R8 reset outputs", {out_q, out_i}, 128'(0));
        check("R8 reset valid/err", 128'({out_valid, cfg_err}), 128'(0));
        rst_n = 1'b1;
        cur = 32'hF3F2F1F0;
        err_m = 1'b0;
        sample("R8 default routing", mk(1), cur);
        held = {out_q, out_i};
        @(negedge clk);
        check("R7 hold when idle", {out_q, out_i}, held);
        check("R7 valid low", 128'(out_valid), 128'(0));

        for (int v = 0; v < 9; v++) begin
            wr(VECS[v][32:1]);
            if (!VECS[v][0]) err_m = 1'b1;
            check("R4 error flag", 128'(cfg_err), 128'(err_m));
            sample(VECS[v][0] ? "R6 old routing first" : "R5 illegal ignored", mk(10 + v), cur);
            if (VECS[v][0]) cur = VECS[v][32:1];
            sample(VECS[v][0] ? "R1 R2 R3 new routing" : "R5 routing kept", mk(30 + v), cur);
        end

        // last write wins, back-to-back samples
        wr(32'h00000000);
        wr(32'h11223300);
        @(negedge clk); adc_valid = 1'b1; adc_data = mk(50);
        @(negedge clk); adc_data = mk(51);
        check("R6 first sample old", {out_q, out_i}, route(cur, mk(50)));
        cur = 32'h11223300;
        @(negedge clk); adc_valid = 1'b0;
        check("R9 last write wins", {out_q, out_i}, route(cur, mk(51)));
        check("R7 back-to-back valid", 128'(out_valid), 128'(1));
        check("R4 error still set", 128'(cfg_err), 128'(1));

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R8 reset clears error", 128'(cfg_err), 128'(0));
        sample("R8 routing after reset", mk(60), 32'hF3F2F1F0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule